// File: doc/BRIEF.md
# Power Domain and Module State Sequencer

This block sits behind a 32-bit register port and sequences the power state of a small set of domains and the clock and reset state of the modules they hold. Software first stages a target state for each module and a target power state for each domain. It then commits a whole domain at once with a one-shot go bit. Every module owned by that domain then walks through encoded in-progress steps until it reaches its target. A per-domain busy bit stays set until the last owned module has settled.

Each module drives a clock-enable and an active-low reset output. A read-only configuration word per module reports which domain owns it and whether it can isolate its reset. The power switches, isolation cells and clock gates themselves are outside the block and see only its output pins. The register port is plain control access: a write strobe commits in the clock edge it is sampled, and read data is a combinational function of the address. There is no back-pressure.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset every module reads status code 0 with bit 8 set, all clock enables, module resets and domain power outputs are low, and the busy word reads 0.
- R2: Word addresses are decoded as follows: go at 0x120, busy at 0x128, domain status at 0x200+4n, domain control at 0x300+4n, module configuration at 0x600+4n, module status at 0x800+4n, module control at 0xA00+4n. Reads of any other address, or of an index at or beyond the count, return 0. Writes to read-only or unmapped addresses change nothing.
- R3: Module control holds the staged state code in bits [4:0], the local reset (active low) in bit 8 and the reset-isolation enable in bit 12. On a module whose configuration bit 14 is 0, bit 12 is dropped and reads back 0.
- R4: Module configuration is read-only and reads the owning domain in bits [20:16] and reset-isolation support in bit 14.
- R5: Writing 1 to bit n of the go word starts a transition of domain n. From the following cycle bit n of the busy word reads 1 until every module of the domain has settled, and it clears one cycle after that. The go word reads 0.
- R6: Enabling a module (staged code 3) from a settled non-on state shows status 0x24 for STEP_CYC cycles and then 3.
- R7: Disabling an on module (staged code 2 or 0) shows 0x20, 0x21 and 0x22 in that order, each for STEP_CYC cycles, and then the staged code.
- R8: Moving between codes 0 and 2 takes effect in the cycle after the go. A staged code equal to the current state, or any code other than 0, 2 or 3, leaves the module unchanged and the busy bit clears one cycle after it was set.
- R9: A go for a domain whose busy bit reads 1 in that cycle, including the cycle in which it is about to clear, is ignored.
- R10: A go applies the staged codes of all modules of that domain and of no other module.
- R11: A module clock enable is high exactly while its status code is 3. A module reset output is high only when its local reset bit is 1 and its status code is not 0.
- R12: Module status bit 8 shows the local reset bit one cycle after it is written, and bit 9 (reset done) reads as its inverse.
- R13: Domain control reads back its power bit (bit 0, 1 = on) and mode field (bits [15:12]). Domain status bits [4:0] and the domain power output take the staged power bit when that domain's transition completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, committed at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| mod_clk_en | output | NUM_MOD | Per-module clock enable |
| mod_rst_n | output | NUM_MOD | Per-module active-low reset |
| dom_pwr_on | output | NUM_DOM | Per-domain power-on request |

## Verification
A new go for a domain and the release of that domain's busy bit can land on the same clock edge; the rule is that the go loses. The bench times a go write so that it commits on exactly the edge at which the busy bit falls, with a different module code staged beforehand. It then expects the busy bit to stay clear and that module to keep its old status code, which would change only if the go had been accepted. Clock-enable and reset pins are compared cycle by cycle through a queue of expected values whose timing is derived from STEP_CYC.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int REG_AW = 12;
  localparam int REG_DW = 32;
  localparam int IDX_W  = 6;

  // status codes seen by software and by the sequencer
  typedef enum logic [5:0] {
    MS_SWRST = 6'h00,
    MS_OFF   = 6'h02,
    MS_ON    = 6'h03,
    MS_DIS1  = 6'h20,
    MS_DIS2  = 6'h21,
    MS_DIS3  = 6'h22,
    MS_ENIP  = 6'h24
  } mstate_e;

  localparam logic [4:0] NX_SWRST = 5'd0;
  localparam logic [4:0] NX_OFF   = 5'd2;
  localparam logic [4:0] NX_ON    = 5'd3;

  // word addresses and region selectors
  localparam logic [REG_AW-1:0] ADR_GO   = 12'h120;
  localparam logic [REG_AW-1:0] ADR_BUSY = 12'h128;
  localparam logic [3:0] RGN_DSTAT = 4'h2;
  localparam logic [3:0] RGN_DCTL  = 4'h3;
  localparam logic [3:0] RGN_MCFG  = 4'h6;
  localparam logic [3:0] RGN_MSTAT = 4'h8;
  localparam logic [3:0] RGN_MCTL  = 4'hA;

endpackage

// File: rtl/pwrseq_mod_fsm.sv
module pwrseq_mod_fsm
  import pwrseq_pkg::*;
#(
  parameter int STEP_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       apply,
  input  logic [4:0] target,
  output mstate_e    state,
  output logic       settled,
  output logic       clk_en
);

  localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(STEP_CYC - 1);

  logic [CW-1:0] cnt;
  logic          end_off;   // 1: disable ends in OFF, 0: in SWRST

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= MS_SWRST;
      cnt     <= '0;
      end_off <= 1'b0;
    end else begin
      unique case (state)
        MS_ON, MS_OFF, MS_SWRST: begin
          if (apply) begin
            if (target == NX_ON && state != MS_ON) begin
              state <= MS_ENIP;
              cnt   <= RELOAD;
            end else if ((target == NX_OFF || target == NX_SWRST) && state == MS_ON) begin
              state   <= MS_DIS1;
              cnt     <= RELOAD;
              end_off <= (target == NX_OFF);
            end else if (target == NX_OFF) begin
              state <= MS_OFF;
            end else if (target == NX_SWRST) begin
              state <= MS_SWRST;
            end
          end
        end
        MS_ENIP, MS_DIS1, MS_DIS2, MS_DIS3: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            cnt <= RELOAD;
            case (state)
              MS_ENIP: state <= MS_ON;
              MS_DIS1: state <= MS_DIS2;
              MS_DIS2: state <= MS_DIS3;
              default: state <= end_off ? MS_OFF : MS_SWRST;
            endcase
          end
        end
        default: state <= MS_SWRST;
      endcase
    end
  end

  assign settled = (state == MS_ON) || (state == MS_OFF) || (state == MS_SWRST);
  assign clk_en  = (state == MS_ON);

  AST_ENABLE_VIA_ENIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en) |-> $past(state) == MS_ENIP) else $error("enable skipped 0x24"); // R6

  AST_DIS2_AFTER_DIS1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MS_DIS2 && $past(state) != MS_DIS2) |-> $past(state) == MS_DIS1)
    else $error("disable step order"); // R7

  AST_DIS3_AFTER_DIS2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MS_DIS3 && $past(state) != MS_DIS3) |-> $past(state) == MS_DIS2)
    else $error("disable step order"); // R7

  AST_CLKEN_DROP_TO_DIS1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_en) |-> state == MS_DIS1) else $error("clock dropped outside disable"); // R11

endmodule

// File: rtl/pwrseq_dom_ctl.sv
module pwrseq_dom_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic go_req,
  input  logic next_on,
  input  logic owned_settled,
  output logic accept,
  output logic busy,
  output logic pwr_on
);

  logic tgt_on;

  assign accept = go_req && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tgt_on <= 1'b0;
      pwr_on <= 1'b0;
    end else if (accept) begin
      busy   <= 1'b1;
      tgt_on <= next_on;
    end else if (busy && owned_settled) begin
      busy   <= 1'b0;
      pwr_on <= tgt_on;
    end
  end

  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(owned_settled)) else $error("busy fell early"); // R5

  AST_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go_req && !owned_settled) |=> busy) else $error("busy go restarted"); // R9

  AST_PWR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on != $past(pwr_on)) |-> $fell(busy)) else $error("power moved mid-transition"); // R13

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int NUM_DOM  = 4,
  parameter int NUM_MOD  = 8,
  parameter int STEP_CYC = 4,
  parameter logic [NUM_MOD*5-1:0] MOD_DOM_MAP = {5'd3, 5'd2, 5'd2, 5'd2, 5'd1, 5'd1, 5'd0, 5'd0},
  parameter logic [NUM_MOD-1:0]   ISO_CAP     = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic [NUM_MOD-1:0] mod_clk_en,
  output logic [NUM_MOD-1:0] mod_rst_n,
  output logic [NUM_DOM-1:0] dom_pwr_on
);

  // ---------------- address decode ----------------
  logic [3:0]       rgn;
  logic [IDX_W-1:0] idx;
  logic             at_go, at_busy;

  assign rgn     = reg_addr[11:8];
  assign idx     = reg_addr[7:2];
  assign at_go   = (reg_addr[11:2] == ADR_GO[11:2]);
  assign at_busy = (reg_addr[11:2] == ADR_BUSY[11:2]);

  // ---------------- state ----------------
  logic [NUM_MOD-1:0][4:0] ctl_next;
  logic [NUM_MOD-1:0]      ctl_lrst_n, ctl_iso, lrst_q;
  logic [NUM_DOM-1:0]      dctl_on;
  logic [NUM_DOM-1:0][3:0] dctl_mode;

  mstate_e                 mstate [NUM_MOD];
  logic [NUM_MOD-1:0]      mod_settled, mod_apply;
  logic [NUM_DOM-1:0][NUM_MOD-1:0] own_mask;
  logic [NUM_DOM-1:0]      dom_accept, dom_busy, dom_settled;

  // ---------------- per-module logic ----------------
  for (genvar i = 0; i < NUM_MOD; i++) begin : g_mod
    localparam int DI = int'(MOD_DOM_MAP[i*5 +: 5]);

    logic wr_hit;
    assign wr_hit = reg_wr && (rgn == RGN_MCTL) && (idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_next[i]   <= NX_SWRST;
        ctl_lrst_n[i] <= 1'b1;
        ctl_iso[i]    <= 1'b0;
        lrst_q[i]     <= 1'b1;
      end else begin
        lrst_q[i] <= ctl_lrst_n[i];
        if (wr_hit) begin
          ctl_next[i]   <= reg_wdata[4:0];
          ctl_lrst_n[i] <= reg_wdata[8];
          ctl_iso[i]    <= reg_wdata[12] & ISO_CAP[i];
        end
      end
    end

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_own
      assign own_mask[d][i] = (DI == d);
    end

    if (DI < NUM_DOM) begin : g_apply
      assign mod_apply[i] = dom_accept[DI];
    end else begin : g_orphan
      assign mod_apply[i] = 1'b0;
    end

    pwrseq_mod_fsm #(.STEP_CYC(STEP_CYC)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .apply   (mod_apply[i]),
      .target  (ctl_next[i]),
      .state   (mstate[i]),
      .settled (mod_settled[i]),
      .clk_en  (mod_clk_en[i])
    );

    assign mod_rst_n[i] = ctl_lrst_n[i] && (mstate[i] != MS_SWRST);
  end

  // ---------------- per-domain logic ----------------
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic wr_hit;
    assign wr_hit = reg_wr && (rgn == RGN_DCTL) && (idx == IDX_W'(d));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dctl_on[d]   <= 1'b0;
        dctl_mode[d] <= 4'd0;
      end else if (wr_hit) begin
        dctl_on[d]   <= reg_wdata[0];
        dctl_mode[d] <= reg_wdata[15:12];
      end
    end

    assign dom_settled[d] = &(mod_settled | ~own_mask[d]);

    pwrseq_dom_ctl u_dom (
      .clk           (clk),
      .rst_n         (rst_n),
      .go_req        (reg_wr && at_go && reg_wdata[d]),
      .next_on       (dctl_on[d]),
      .owned_settled (dom_settled[d]),
      .accept        (dom_accept[d]),
      .busy          (dom_busy[d]),
      .pwr_on        (dom_pwr_on[d])
    );
  end

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    if (at_busy) begin
      reg_rdata = REG_DW'(dom_busy);
    end else if (!at_go) begin
      for (int d = 0; d < NUM_DOM; d++) begin
        if (idx == IDX_W'(d)) begin
          if (rgn == RGN_DSTAT) reg_rdata = {27'd0, 4'd0, dom_pwr_on[d]};
          if (rgn == RGN_DCTL)  reg_rdata = {16'd0, dctl_mode[d], 11'd0, dctl_on[d]};
        end
      end
      for (int i = 0; i < NUM_MOD; i++) begin
        if (idx == IDX_W'(i)) begin
          if (rgn == RGN_MCFG)
            reg_rdata = {11'd0, MOD_DOM_MAP[i*5 +: 5], 1'b0, ISO_CAP[i], 14'd0};
          if (rgn == RGN_MSTAT)
            reg_rdata = {22'd0, ~lrst_q[i], lrst_q[i], 2'b00, mstate[i]};
          if (rgn == RGN_MCTL)
            reg_rdata = {19'd0, ctl_iso[i], 3'd0, ctl_lrst_n[i], 3'd0, ctl_next[i]};
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_MOD; i++) begin : g_chk
    AST_NO_ISO_WITHOUT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      !ISO_CAP[i] |-> !ctl_iso[i]) else $error("iso bit kept"); // R3

    AST_RESET_LATCH_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      lrst_q[i] == $past(ctl_lrst_n[i])) else $error("local reset status lag"); // R12
  end

endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;

  localparam int NM = 8;
  localparam int ND = 4;
  localparam int SC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NM-1:0] mod_clk_en, mod_rst_n;
  logic [ND-1:0] dom_pwr_on;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_seq_ctrl i_pwr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mod_clk_en(mod_clk_en),
    .mod_rst_n(mod_rst_n), .dom_pwr_on(dom_pwr_on)
  );

  // ---------------- scoreboard for module pins ----------------
  int          q_cyc [$];
  bit          q_sel [$];   // 0: clock enables, 1: resets
  logic [NM-1:0] q_mask [$];
  logic [NM-1:0] q_val  [$];
  string       q_tag [$];

  task automatic exp_pin(input int at, input bit sel, input logic [NM-1:0] m,
                         input logic [NM-1:0] v, input string tag);
    q_cyc.push_back(at); q_sel.push_back(sel); q_mask.push_back(m);
    q_val.push_back(v);  q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      logic [NM-1:0] act;
      act = (q_sel[0] ? mod_rst_n : mod_clk_en) & q_mask[0];
      nchk++;
      if (q_cyc[0] != cyc || act != q_val[0]) begin
        nerr++;
        $display("FAIL %s cycle %0d pins act=%h exp=%h", q_tag[0], q_cyc[0], act, q_val[0]);
      end
      void'(q_cyc.pop_front()); void'(q_sel.pop_front()); void'(q_mask.pop_front());
      void'(q_val.pop_front()); void'(q_tag.pop_front());
    end
  end

  // ---------------- driver helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wait_to(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int e0, e1, e2, e3, e4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 clk_en", 32'(mod_clk_en), 32'h0);
    chk("R1 rst_n", 32'(mod_rst_n), 32'h0);
    chk("R1 pwr_on", 32'(dom_pwr_on), 32'h0);
    rd_chk("R1 mod0 status", 12'h800, 32'h100);
    rd_chk("R1 busy", 12'h128, 32'h0);

    // R4 config, R2 decode
    rd_chk("R4 cfg mod1", 12'h604, 32'h0000_4000);
    rd_chk("R4 cfg mod4", 12'h610, 32'h0002_0000);
    rd_chk("R4 cfg mod7", 12'h61C, 32'h0003_0000);
    wr(12'h604, 32'hFFFF_FFFF);
    rd_chk("R2 cfg write ignored", 12'h604, 32'h0000_4000);
    wr(12'h128, 32'hF);
    rd_chk("R2 busy write ignored", 12'h128, 32'h0);
    rd_chk("R2 unmapped", 12'h124, 32'h0);
    rd_chk("R2 dom idx out", 12'h310, 32'h0);
    rd_chk("R2 mod idx out", 12'hA20, 32'h0);

    // R13 domain control, R3 module control
    wr(12'h300, 32'h0000_A001);
    rd_chk("R13 dctl readback", 12'h300, 32'h0000_A001);
    wr(12'hA00, 32'h0000_1103);
    rd_chk("R3 mctl iso kept", 12'hA00, 32'h0000_1103);
    wr(12'hA04, 32'h0000_0103);
    wr(12'hA10, 32'h0000_1103);
    rd_chk("R3 mctl iso dropped", 12'hA10, 32'h0000_0103);
    wr(12'hA10, 32'h0000_0100);

    // R5 R6 enable domain 0
    wr(12'h120, 32'h1);
    e0 = cyc;
    exp_pin(e0 + SC - 1, 1'b0, 8'h03, 8'h00, "R6 clk_en before done");
    exp_pin(e0 + SC,     1'b0, 8'h03, 8'h03, "R11 clk_en on");
    rd_chk("R6 mod0 enable in progress", 12'h800, 32'h124);
    rd_chk("R5 busy set", 12'h128, 32'h1);
    rd_chk("R5 go reads zero", 12'h120, 32'h0);
    rd_chk("R10 mod2 untouched", 12'h808, 32'h100);
    rd_chk("R13 dom status pending", 12'h200, 32'h0);
    wait_to(e0 + SC - 1);
    rd_chk("R6 mod1 still in progress", 12'h804, 32'h124);
    wait_to(e0 + SC);
    rd_chk("R6 mod0 on", 12'h800, 32'h103);
    rd_chk("R5 busy held", 12'h128, 32'h1);
    wait_to(e0 + SC + 1);
    rd_chk("R5 busy cleared", 12'h128, 32'h0);
    rd_chk("R13 dom0 status on", 12'h200, 32'h1);
    chk("R13 pwr_on dom0", 32'(dom_pwr_on), 32'h1);
    chk("R11 rst_n mods 0 1", 32'(mod_rst_n & 8'h03), 32'h3);
    rd_chk("R10 mod4 untouched", 12'h810, 32'h100);

    // R9 domain 1: go while busy and go on the clearing edge
    wr(12'hA08, 32'h0000_0103);
    wr(12'hA0C, 32'h0000_0100);
    wr(12'h120, 32'h2);
    e0 = cyc;
    exp_pin(e0 + SC, 1'b0, 8'h04, 8'h04, "R6 mod2 clk_en");
    wr(12'hA08, 32'h0000_0102);
    wr(12'h120, 32'h2);
    wr(12'hA0C, 32'h0000_0102);
    wait_to(e0 + SC);
    wr(12'h120, 32'h2);
    rd_chk("R9 coincident go ignored busy", 12'h128, 32'h0);
    rd_chk("R9 mod2 stays on", 12'h808, 32'h103);
    rd_chk("R9 mod3 unchanged", 12'h80C, 32'h100);
    wait_to(e0 + SC + 3);
    rd_chk("R9 busy stays clear", 12'h128, 32'h0);
    rd_chk("R9 mod3 still unchanged", 12'h80C, 32'h100);

    // R7 R8 disable domain 1
    wr(12'h120, 32'h2);
    e1 = cyc;
    exp_pin(e1, 1'b0, 8'h04, 8'h00, "R11 mod2 clk_en off");
    rd_chk("R8 mod3 direct to off", 12'h80C, 32'h102);
    rd_chk("R7 step1", 12'h808, 32'h120);
    rd_chk("R5 busy dom1", 12'h128, 32'h2);
    wait_to(e1 + SC - 1);
    rd_chk("R7 step1 held", 12'h808, 32'h120);
    wait_to(e1 + SC);
    rd_chk("R7 step2", 12'h808, 32'h121);
    wait_to(e1 + 2*SC);
    rd_chk("R7 step3", 12'h808, 32'h122);
    wait_to(e1 + 3*SC);
    rd_chk("R7 off reached", 12'h808, 32'h102);
    rd_chk("R5 busy until settled", 12'h128, 32'h2);
    wait_to(e1 + 3*SC + 1);
    rd_chk("R5 busy clear dom1", 12'h128, 32'h0);

    // R12 R11 local reset, then R7 disable to code 0 on domain 0
    wr(12'hA00, 32'h0000_1000);
    e2 = cyc;
    chk("R11 local reset drives pin", 32'(mod_rst_n & 8'h01), 32'h0);
    chk("R11 clk_en unaffected", 32'(mod_clk_en & 8'h01), 32'h1);
    rd_chk("R12 status before lag", 12'h800, 32'h103);
    wait_to(e2 + 1);
    rd_chk("R12 status after lag", 12'h800, 32'h203);
    wr(12'hA04, 32'h0000_0102);
    wr(12'h300, 32'h0000_A000);
    wr(12'h120, 32'h1);
    e3 = cyc;
    exp_pin(e3, 1'b0, 8'h03, 8'h00, "R11 dom0 clocks off");
    exp_pin(e3 + 3*SC, 1'b1, 8'h03, 8'h02, "R11 resets after disable");
    rd_chk("R7 mod0 step1", 12'h800, 32'h220);
    wait_to(e3 + 3*SC);
    rd_chk("R7 mod0 to swrst", 12'h800, 32'h200);
    rd_chk("R7 mod1 to off", 12'h804, 32'h102);
    wait_to(e3 + 3*SC + 1);
    rd_chk("R13 dom0 status off", 12'h200, 32'h0);
    chk("R13 pwr_on dom0 off", 32'(dom_pwr_on), 32'h0);

    // R8 unsupported code on domain 2
    wr(12'hA14, 32'h0000_0101);
    wr(12'h120, 32'h4);
    e4 = cyc;
    rd_chk("R8 busy set dom2", 12'h128, 32'h4);
    rd_chk("R8 mod5 unchanged", 12'h814, 32'h100);
    wait_to(e4 + 1);
    rd_chk("R8 busy clears next", 12'h128, 32'h0);
    rd_chk("R8 mod5 still unchanged", 12'h814, 32'h100);

    repeat (3) @(negedge clk);
    if (q_cyc.size() != 0) begin
      nchk++; nerr++;
      $display("FAIL scoreboard left %0d items act=%0d exp=0", q_cyc.size(), q_cyc.size());
    end
    finish_run();
  end

endmodule